// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command interface of a parallel NOR flash model, limited to erasing. It watches single-cycle bus writes, each carrying an address and a data byte, and recognises two six-write sequences. Each sequence starts with a pair of unlock writes, then a set-up byte, then a second unlock pair, and ends with either a whole-chip erase command or a sector erase command whose address names the sector. A chip erase runs straight away for a fixed number of clock cycles and cannot be interrupted by any write.

A sector erase first opens an acceptance window that is counted in clock cycles. Each further sector-erase write inside the window marks one more sector in an erase buffer and restarts the window. When the window runs out, the erase itself runs for a fixed number of cycles. A suspend byte stops the erase. Written inside the window it acts at once. Written during the erase it acts after a fixed latency. While the erase is suspended, reads from sectors outside the buffer see array data and reads from buffered sectors see status. A resume byte continues the erase for the time that was left.

Writes arrive as plain strobes with no back-pressure. Each strobe is consumed on the cycle it is high: it either advances the sequencer or is dropped. The block reports busy, timer-expired, suspended, and a per-read select between array data and status data. The memory array itself is not part of this block.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, tmr_expired, suspended and rd_status are all 0 (read mode).
- R2: The prefix writes are, in this order: address low 12 bits 0x555 with data 0xAA; 0x2AA with 0x55; 0x555 with 0x80; 0x555 with 0xAA; 0x2AA with 0x55. A write that does not match the expected step returns the block to read mode. After that, a new full sequence is accepted.
- R3: After the prefix, a write of 0x10 to 0x555 starts chip erase. busy and tmr_expired then stay 1 for exactly ERASE_CYC cycles, and every write in that time is ignored, including 0xB0. The block then returns to read mode.
- R4: After the prefix, a write of 0x30 starts sector erase for the sector held in wr_addr bits [14:12]. During the next WIN_CYC cycles busy=1 and tmr_expired=0. After that, tmr_expired=1.
- R5: A 0x30 write inside the window adds its sector to the buffer and restarts the window. busy=1 with tmr_expired=0 then lasts WIN_CYC cycles counted from that write.
- R6: Inside the window, any write whose data is neither 0x30 nor 0xB0 returns the block to read mode (busy=0) without erasing, and it empties the buffer.
- R7: A sector erase runs for ERASE_CYC cycles with busy=1 and tmr_expired=1. The block then returns to read mode and the buffer is empty.
- R8: Once a sector erase is running, every write other than 0xB0 is ignored, and the erase time stays ERASE_CYC.
- R9: 0xB0 written inside the window suspends on the next cycle (suspended=1, busy=0). The address of that write is ignored.
- R10: 0xB0 written during a sector erase raises suspended exactly SUSP_LAT cycles after the write.
- R11: rd_status is 1 for every rd_sect while busy. While suspended it is 1 exactly for the buffered sectors. In read mode it is 0. Writes other than 0x30 leave a suspended block suspended.
- R12: 0x30 written while suspended resumes the erase. The cycles with busy=1 and tmr_expired=1 before and after the suspend add up to ERASE_CYC.
- R13: Asserting rst_n low during an erase ends it at once. All outputs drop to 0, and a new sequence is accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | 12+log2(NSECT) | Write address: low 12 bits are the command address, upper bits the sector |
| wr_data | input | 8 | Write data byte (command code) |
| rd_sect | input | log2(NSECT) | Sector of the current read address |
| busy | output | 1 | 1 while an erase or the acceptance window is in progress |
| tmr_expired | output | 1 | 1 once the acceptance window is closed (also in chip erase and suspend) |
| suspended | output | 1 | 1 while a sector erase is suspended |
| rd_status | output | 1 | 1 = reads of rd_sect return status data, 0 = array data |

## Verification
A wrong sequencer state shows up within one cycle on the flags. A dropped or wrongly accepted unlock step leaves busy low, or raises it, right after the final write. A wrong window or erase count shows up as a busy phase that is longer or shorter than its parameter, so the bench counts cycles phase by phase. A wrong erase buffer is invisible until the block is suspended, and then rd_status gives the wrong answer for some sector. For that reason, random sector sets are each suspended, and every sector is probed. A lost remaining time shows up only after resume, as a total erase length that differs from ERASE_CYC.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int CMD_AW = 12;

  localparam logic [CMD_AW-1:0] ADR_KEY1 = 12'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 12'h2AA;

  localparam logic [7:0] DAT_KEY1   = 8'hAA;
  localparam logic [7:0] DAT_KEY2   = 8'h55;
  localparam logic [7:0] DAT_SETUP  = 8'h80;
  localparam logic [7:0] DAT_CHIP   = 8'h10;
  localparam logic [7:0] DAT_SECTOR = 8'h30;
  localparam logic [7:0] DAT_PAUSE  = 8'hB0;
  localparam logic [7:0] DAT_RESUME = 8'h30;

  typedef enum logic [3:0] {
    ST_READ,
    ST_KEY_A,
    ST_KEY_B,
    ST_ARMED,
    ST_KEY_C,
    ST_KEY_D,
    ST_WINDOW,
    ST_CHIP,
    ST_ERASE,
    ST_SUSP
  } fes_state_t;
endpackage

// File: rtl/fes_countdown.sv
module fes_countdown #(
  parameter int MAXV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(MAXV + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= CW'(MAXV);
    else if (run && cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign expire = run && !load && (cnt == CW'(1));

  // R4 R7 R10: the counter never leaves its configured range
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAXV));

  // R5: a reload restarts the full interval
  a_r5_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == CW'(MAXV)));
endmodule

// File: rtl/fes_sector_buf.sv
module fes_sector_buf #(
  parameter int NSECT = 8,
  parameter int IW    = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set,
  input  logic [IW-1:0]    set_idx,
  input  logic [IW-1:0]    q_idx,
  output logic             hit,
  output logic [NSECT-1:0] mask
);
  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask[g] <= 1'b0;
      else if (clr)                             mask[g] <= 1'b0;
      else if (set && (set_idx == IW'(g)))      mask[g] <= 1'b1;
    end
  end

  assign hit = mask[q_idx];

  // R5: a marked sector is held on the next cycle
  a_r5_mark_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> mask[$past(set_idx)]);

  // R7: release empties the buffer
  a_r7_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int NSECT     = 8,
  parameter int WIN_CYC   = 8,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 4,
  parameter int SECT_W    = $clog2(NSECT),
  parameter int ADDR_W    = CMD_AW + SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SECT_W-1:0] rd_sect,
  output logic              busy,
  output logic              tmr_expired,
  output logic              suspended,
  output logic              rd_status
);
  fes_state_t st, nxt;

  logic [CMD_AW-1:0] cmd_adr;
  logic [SECT_W-1:0] wr_sect;
  logic key1, key2, setup_ok;
  logic win_load, win_exp, er_load, er_run, er_exp;
  logic lat_load, lat_run, lat_exp, pend, pend_set;
  logic buf_set, buf_clr, buf_hit;
  logic [NSECT-1:0] buf_mask;

  assign cmd_adr  = wr_addr[CMD_AW-1:0];
  assign wr_sect  = wr_addr[ADDR_W-1 -: SECT_W];
  assign key1     = (cmd_adr == ADR_KEY1) && (wr_data == DAT_KEY1);
  assign key2     = (cmd_adr == ADR_KEY2) && (wr_data == DAT_KEY2);
  assign setup_ok = (cmd_adr == ADR_KEY1) && (wr_data == DAT_SETUP);

  always_comb begin
    nxt      = st;
    win_load = 1'b0;
    er_load  = 1'b0;
    lat_load = 1'b0;
    pend_set = 1'b0;
    buf_set  = 1'b0;
    unique case (st)
      ST_READ:  if (wr_en && key1) nxt = ST_KEY_A;
      ST_KEY_A: if (wr_en) nxt = key2     ? ST_KEY_B : ST_READ;
      ST_KEY_B: if (wr_en) nxt = setup_ok ? ST_ARMED : ST_READ;
      ST_ARMED: if (wr_en) nxt = key1     ? ST_KEY_C : ST_READ;
      ST_KEY_C: if (wr_en) nxt = key2     ? ST_KEY_D : ST_READ;
      ST_KEY_D: if (wr_en) begin
        if (wr_data == DAT_CHIP && cmd_adr == ADR_KEY1) begin
          nxt     = ST_CHIP;
          er_load = 1'b1;
        end else if (wr_data == DAT_SECTOR) begin
          nxt      = ST_WINDOW;
          win_load = 1'b1;
          buf_set  = 1'b1;
        end else begin
          nxt = ST_READ;
        end
      end
      ST_WINDOW: begin
        if (wr_en) begin
          if (wr_data == DAT_SECTOR) begin
            win_load = 1'b1;
            buf_set  = 1'b1;
          end else if (wr_data == DAT_PAUSE) begin
            nxt     = ST_SUSP;
            er_load = 1'b1;
          end else begin
            nxt = ST_READ;
          end
        end else if (win_exp) begin
          nxt     = ST_ERASE;
          er_load = 1'b1;
        end
      end
      ST_CHIP: if (er_exp) nxt = ST_READ;
      ST_ERASE: begin
        if (er_exp) begin
          nxt = ST_READ;
        end else begin
          if (lat_exp) nxt = ST_SUSP;
          if (wr_en && wr_data == DAT_PAUSE && !pend) begin
            lat_load = 1'b1;
            pend_set = 1'b1;
          end
        end
      end
      ST_SUSP: if (wr_en && wr_data == DAT_RESUME) nxt = ST_ERASE;
      default: nxt = ST_READ;
    endcase
  end

  assign buf_clr = (nxt == ST_READ);
  assign er_run  = (st == ST_CHIP) || (st == ST_ERASE);
  assign lat_run = (st == ST_ERASE) && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_READ;
      pend <= 1'b0;
    end else begin
      st   <= nxt;
      pend <= pend_set || (pend && nxt == ST_ERASE);
    end
  end

  fes_countdown #(.MAXV(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load),
    .run(st == ST_WINDOW), .expire(win_exp)
  );

  fes_countdown #(.MAXV(ERASE_CYC)) u_erase (
    .clk(clk), .rst_n(rst_n), .load(er_load),
    .run(er_run), .expire(er_exp)
  );

  fes_countdown #(.MAXV(SUSP_LAT)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(lat_load),
    .run(lat_run), .expire(lat_exp)
  );

  fes_sector_buf #(.NSECT(NSECT), .IW(SECT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .set(buf_set),
    .set_idx(wr_sect), .q_idx(rd_sect), .hit(buf_hit), .mask(buf_mask)
  );

  assign busy        = (st == ST_WINDOW) || (st == ST_CHIP) || (st == ST_ERASE);
  assign tmr_expired = (st == ST_CHIP) || (st == ST_ERASE) || (st == ST_SUSP);
  assign suspended   = (st == ST_SUSP);
  assign rd_status   = busy || (suspended && buf_hit);

  // R3: chip erase stays busy until its timer fires, whatever is written
  a_r3_chip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHIP && !er_exp) |=> (st == ST_CHIP));

  // R8: the erase buffer is frozen while sectors are being erased
  a_r8_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && !er_exp) |=> $stable(buf_mask));

  // R6 R7: read mode never holds latched sectors
  a_r6_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) |-> (buf_mask == '0));

  // R10: a pending suspend exists only during a running sector erase
  a_r10_pend_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (st == ST_ERASE));

  // R11: a suspended erase always has at least one buffered sector
  a_r11_susp_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (buf_mask != '0));
endmodule

// File: tb/flash_erase_seq_bench.sv
`timescale 1ns/1ps
module flash_erase_seq_bench;
  localparam int NSECT = 8;
  localparam int WIN   = 8;
  localparam int ER    = 40;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_sect = '0;
  logic        busy, tmr_expired, suspended, rd_status;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_erase_seq #(.NSECT(NSECT), .WIN_CYC(WIN), .ERASE_CYC(ER), .SUSP_LAT(LAT))
  u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sect(rd_sect), .busy(busy), .tmr_expired(tmr_expired),
    .suspended(suspended), .rd_status(rd_status)
  );

  function automatic logic [14:0] sect_addr(input int s);
    return {3'(s), 12'h000};
  endfunction

  function automatic bit exp_status(input logic [7:0] m, input int s);
    return m[s];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prefix();
    wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(15'h555, 8'h80);
    wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55);
  endtask

  // kind 0: window phase, 1: erase phase, 2: waiting for suspend
  task automatic count_phase(input int kind, input bit noise, input bit allow_pause,
                             output int n);
    n = 0;
    while ((kind == 0 && busy && !tmr_expired) ||
           (kind == 1 && busy && tmr_expired) ||
           (kind == 2 && busy && !suspended)) begin
      n++;
      if (noise) begin
        wr_en   = 1'b1;
        wr_addr = 15'($urandom);
        wr_data = 8'($urandom);
        if (!allow_pause && wr_data == 8'hB0) wr_data = 8'h00;
      end
      @(negedge clk);
      if (n > 4 * ER) break;
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, e, k;
    logic [7:0] m;
    bit first;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(tmr_expired == 0, "R1 tmr_expired", tmr_expired, 0);
    check(suspended == 0, "R1 suspended", suspended, 0);
    check(rd_status == 0, "R1 rd_status", rd_status, 0);

    // R3 chip erase with noise including 0xB0
    prefix(); wr(15'h555, 8'h10);
    check(busy == 1, "R3 busy after chip cmd", busy, 1);
    check(rd_status == 1, "R11 status while busy", rd_status, 1);
    count_phase(1, 1'b1, 1'b1, n);
    check(n == ER, "R3 chip erase length", n, ER);
    check(busy == 0 && rd_status == 0, "R3 back to read", busy, 0);

    // R4 R7 single sector
    prefix(); wr(sect_addr(3), 8'h30);
    count_phase(0, 1'b0, 1'b0, n);
    check(n == WIN, "R4 window length", n, WIN);
    check(tmr_expired == 1, "R4 timer expired", tmr_expired, 1);
    count_phase(1, 1'b0, 1'b0, n);
    check(n == ER, "R7 sector erase length", n, ER);
    rd_sect = 3'd3;
    #1 check(busy == 0 && rd_status == 0, "R7 released", rd_status, 0);

    // R5 restart, R8 noise during erase
    prefix(); wr(sect_addr(1), 8'h30);
    repeat (5) @(negedge clk);
    wr(sect_addr(6), 8'h30);
    count_phase(0, 1'b0, 1'b0, n);
    check(n == WIN, "R5 window restarted", n, WIN);
    count_phase(1, 1'b1, 1'b0, n);
    check(n == ER, "R8 ignored writes keep length", n, ER);

    // R6 abort in window, R9 immediate suspend
    prefix(); wr(sect_addr(5), 8'h30);
    wr(15'h555, 8'hAA);
    check(busy == 0 && tmr_expired == 0, "R6 abort to read", busy, 0);
    prefix(); wr(sect_addr(2), 8'h30);
    wr(15'h7123, 8'hB0);
    check(suspended == 1 && busy == 0, "R9 immediate suspend", suspended, 1);
    rd_sect = 3'd5;
    #1 check(rd_status == 0, "R6 buffer cleared", rd_status, 0);
    rd_sect = 3'd2;
    #1 check(rd_status == 1, "R11 buffered sector", rd_status, 1);
    @(negedge clk);
    wr(15'h0, 8'h30);
    count_phase(1, 1'b0, 1'b0, n);
    check(n == ER, "R12 resume from window", n, ER);

    // R10 latency, R11 reads, R12 remaining time
    prefix(); wr(sect_addr(4), 8'h30);
    count_phase(0, 1'b0, 1'b0, n);
    e = 0;
    repeat (10) begin if (busy && tmr_expired) e++; @(negedge clk); end
    e++;
    wr(15'h0, 8'hB0);
    count_phase(2, 1'b0, 1'b0, n);
    e += n;
    check(n == LAT, "R10 suspend latency", n, LAT);
    rd_sect = 3'd4;
    #1 check(rd_status == 1, "R11 suspended buffered", rd_status, 1);
    rd_sect = 3'd0;
    #1 check(rd_status == 0, "R11 suspended other", rd_status, 0);
    @(negedge clk);
    wr(sect_addr(0), 8'h12);
    check(suspended == 1, "R11 program write keeps suspend", suspended, 1);
    wr(15'h0, 8'h30);
    count_phase(1, 1'b0, 1'b0, n);
    e += n;
    check(e == ER, "R12 total erase time", e, ER);

    // R13 hardware reset during erase
    prefix(); wr(sect_addr(1), 8'h30);
    count_phase(0, 1'b0, 1'b0, n);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1 check(busy == 0 && tmr_expired == 0 && rd_status == 0, "R13 abort", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prefix(); wr(sect_addr(1), 8'h30);
    check(busy == 1 && tmr_expired == 0, "R13 accepts after reset", busy, 1);
    wr(15'h555, 8'hF0);

    // R2 random mismatch position
    for (int it = 0; it < 12; it++) begin
      logic [11:0] ad [6];
      logic [7:0]  dd [6];
      ad = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h000};
      dd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
      k = int'($urandom % 6);
      for (int s = 0; s < k; s++) wr({3'd0, ad[s]}, dd[s]);
      wr({3'd0, ad[k]}, dd[k] ^ 8'h01);
      check(busy == 0 && suspended == 0, "R2 mismatch to read", busy, 0);
      prefix(); wr(sect_addr(it % 8), 8'h30);
      check(busy == 1 && tmr_expired == 0, "R2 new sequence accepted", busy, 1);
      wr(15'h555, 8'hF0);
      check(busy == 0, "R6 abort", busy, 0);
    end

    // R11 R12 random sector sets and suspend points
    for (int it = 0; it < 16; it++) begin
      int o, mode;
      m = 8'($urandom % 255 + 1);
      o = int'($urandom % 8);
      mode = int'($urandom % 2);
      first = 1'b1;
      for (int i = 0; i < 8; i++) begin
        int s;
        s = (o + i) % 8;
        if (m[s]) begin
          if (first) prefix();
          first = 1'b0;
          wr(sect_addr(s), 8'h30);
        end
      end
      e = 0;
      if (mode == 0) begin
        wr(15'h0, 8'hB0);
      end else begin
        count_phase(0, 1'b0, 1'b0, n);
        check(n == WIN, "R5 window after last add", n, WIN);
        k = int'($urandom % 20) + 1;
        repeat (k) begin if (busy && tmr_expired) e++; @(negedge clk); end
        e++;
        wr(15'h0, 8'hB0);
        count_phase(2, 1'b0, 1'b0, n);
        e += n;
      end
      check(suspended == 1, "R11 reached suspend", suspended, 1);
      for (int s = 0; s < 8; s++) begin
        rd_sect = 3'(s);
        #1 check(rd_status == exp_status(m, s), "R11 random status", rd_status,
                 exp_status(m, s));
      end
      @(negedge clk);
      wr(15'h0, 8'h30);
      count_phase(1, 1'b0, 1'b0, n);
      e += n;
      check(e == ER, "R12 random total", e, ER);
      check(busy == 0 && suspended == 0, "R7 random done", busy, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule